// File: doc/BRIEF.md
# NOR Flash Erase Command Controller

This block is the erase half of a parallel NOR flash command interface, modelled around a small behavioural array. The array is organised in blocks grouped into banks, and each block has a protect flag. The controller is taken to be permanently in unlock-bypass mode. A block erase therefore needs only two bus writes: a setup code, then a confirm code written at a block address. Repeating the confirm write at other block addresses while the collection window is open adds those blocks to the job.

When the window closes, the controller erases the selected unprotected blocks one at a time, in ascending block index. Erasing a block fills every word with ones. Protected blocks are skipped silently. A job in which every selected block is protected runs a short dummy interval and leaves the data as it was.

A bus read returns the status word when the address falls in a bank that holds a selected block and an operation is active. A read from any other bank returns array content. The erase can be suspended and later resumed. A fault input forces an error state, which only a reset command clears.

Top module: `nor_erase_ctrl`

## Requirements
- R1: After reset, `rdata_o` is 0 and a read of word address `a` returns the value `a` (truncated to the data width). Read data appears on `rdata_o` one clock after `rd_i` is sampled and holds until the next read.
- R2: In read mode, a write of 80h followed by a write of 30h starts the collection window. The 30h write selects the block given by the upper address bits (block index = addr / BLK_WORDS). If the write after 80h carries any other data, the controller returns to read mode. Any write in read mode other than 80h is ignored.
- R3: Each 30h write during the window adds its block and restarts the window at TMO_CYC cycles. After the erase, every word of an erased block reads FFh.
- R4: Selected blocks whose `prot_i` bit is set keep their data. Skipping them never sets the error bit.
- R5: If every selected block is protected, status reads continue for NOP_CYC cycles after the window closes. The controller then returns to read mode, and no data has changed.
- R6: Unprotected selected blocks are erased one at a time in ascending index order, ERS_CYC cycles each.
- R7: The status word has bit 6 as a toggle, which inverts on every read that returns status. Bit 5 is the error flag. All other bits are 0.
- R8: While the window, an erase, a suspend request or a dummy interval is active, a read from a bank that holds a selected block returns status. A read from any other bank returns array data. Banks are contiguous groups of NUM_BLKS/NUM_BANKS blocks.
- R9: F0h written during the window cancels the job with no data changed. F0h and every other code except B0h are ignored while an erase runs.
- R10: B0h written during the window suspends on the next clock. B0h written during an erase suspends after SUSP_LAT cycles. While suspended, every read returns array data.
- R11: 30h written while suspended resumes the erase. The interrupted block restarts from the beginning, and the remaining selected blocks follow.
- R12: `fault_i` high during an erase enters the error state. In that state every read returns status with bit 5 set, until an F0h write returns the controller to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | AW (5) | Word address: block index in the upper bits, word in the lower bits |
| wdata_i | input | DATA_W (8) | Command code for writes |
| prot_i | input | NUM_BLKS (8) | Per-block protect flags |
| fault_i | input | 1 | Fault injection: forces the error state during an erase |
| rdata_o | output | DATA_W (8) | Read data: array word or status |

## Verification
The hardest situation to reach is a fault that lands after the first block of a two-block job has finished but before the second has. Only there does the ascending erase order show at the ports: the lower block reads FFh and the higher one keeps its content. The stimulus times the last confirm write and counts whole clocks through the restarted window and one full block period before raising `fault_i`. It then clears the error with F0h and reads both blocks back. A suspend request issued partway through an erase is reached the same way: the stimulus counts clocks past the window close, so that the latency cycles, in which status is still returned, can be observed before the suspended state is.

// File: rtl/era_pkg.sv
package era_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_WIN, ST_ERS, ST_SPND, ST_SUSP, ST_NOP, ST_ERR
  } era_st_e;

  localparam logic [7:0] CMD_SETUP = 8'h80;
  localparam logic [7:0] CMD_CONF  = 8'h30;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
  localparam logic [7:0] CMD_RST   = 8'hF0;

  localparam int STAT_TOG = 6;
  localparam int STAT_ERR = 5;
endpackage

// File: rtl/era_array.sv
module era_array #(
  parameter int NUM_BLKS  = 8,
  parameter int BLK_WORDS = 4,
  parameter int DATA_W    = 8,
  parameter int BLK_W     = 3,
  parameter int AW        = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              ers_en_i,
  input  logic [BLK_W-1:0]  ers_blk_i
);
  localparam int NW = NUM_BLKS * BLK_WORDS;

  logic [DATA_W-1:0] mem [NW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NW; i++) mem[i] <= DATA_W'(i);
    end else if (ers_en_i) begin
      for (int w = 0; w < BLK_WORDS; w++)
        mem[int'(ers_blk_i) * BLK_WORDS + w] <= '1;
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/era_ctrl.sv
module era_ctrl import era_pkg::*; #(
  parameter int NUM_BLKS = 8,
  parameter int DATA_W   = 8,
  parameter int BLK_W    = 3,
  parameter int TMO_CYC  = 8,
  parameter int ERS_CYC  = 6,
  parameter int NOP_CYC  = 5,
  parameter int SUSP_LAT = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [BLK_W-1:0]    wr_blk_i,
  input  logic [NUM_BLKS-1:0] prot_i,
  input  logic                fault_i,
  output era_st_e             st_o,
  output logic [NUM_BLKS-1:0] sel_o,
  output logic                ers_en_o,
  output logic [BLK_W-1:0]    ers_blk_o
);
  localparam int M1   = (TMO_CYC > ERS_CYC) ? TMO_CYC : ERS_CYC;
  localparam int M2   = (NOP_CYC > SUSP_LAT) ? NOP_CYC : SUSP_LAT;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  era_st_e             st;
  logic [NUM_BLKS-1:0] sel;
  logic [CW-1:0]       cnt;
  logic [BLK_W-1:0]    tgt;
  logic                tgt_vld;
  logic                is_conf, is_susp, is_rst;

  assign is_conf = wr_i && (wdata_i[7:0] == CMD_CONF);
  assign is_susp = wr_i && (wdata_i[7:0] == CMD_SUSP);
  assign is_rst  = wr_i && (wdata_i[7:0] == CMD_RST);

  // lowest unprotected selected block
  always_comb begin
    tgt     = '0;
    tgt_vld = 1'b0;
    for (int i = NUM_BLKS - 1; i >= 0; i--) begin
      if (sel[i] && !prot_i[i]) begin
        tgt     = BLK_W'(i);
        tgt_vld = 1'b1;
      end
    end
  end

  assign ers_en_o  = (st == ST_ERS) && !fault_i && !is_susp && tgt_vld &&
                     (cnt == CW'(ERS_CYC - 1));
  assign ers_blk_o = tgt;
  assign st_o      = st;
  assign sel_o     = sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st  <= ST_IDLE;
      sel <= '0;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (wr_i && wdata_i[7:0] == CMD_SETUP) st <= ST_CMD;
        ST_CMD: if (wr_i) begin
          if (is_conf) begin
            sel[wr_blk_i] <= 1'b1;
            cnt <= '0;
            st  <= ST_WIN;
          end else st <= ST_IDLE;
        end
        ST_WIN: begin
          if (is_conf) begin
            sel[wr_blk_i] <= 1'b1;
            cnt <= '0;
          end else if (is_susp) begin
            st <= ST_SUSP;
          end else if (is_rst) begin
            st  <= ST_IDLE;
            sel <= '0;
          end else if (cnt == CW'(TMO_CYC - 1)) begin
            cnt <= '0;
            st  <= tgt_vld ? ST_ERS : ST_NOP;
          end else cnt <= cnt + 1'b1;
        end
        ST_ERS: begin
          if (fault_i) begin
            st <= ST_ERR;
          end else if (is_susp) begin
            st  <= ST_SPND;
            cnt <= '0;
          end else if (!tgt_vld) begin
            st  <= ST_IDLE;
            sel <= '0;
          end else if (ers_en_o) begin
            sel[tgt] <= 1'b0;
            cnt      <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_SPND: begin
          if (cnt == CW'(SUSP_LAT - 1)) st <= ST_SUSP;
          else cnt <= cnt + 1'b1;
        end
        ST_SUSP: if (is_conf) begin
          st  <= ST_ERS;
          cnt <= '0;
        end
        ST_NOP: begin
          if (cnt == CW'(NOP_CYC - 1)) begin
            st  <= ST_IDLE;
            sel <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_ERR: if (is_rst) begin
          st  <= ST_IDLE;
          sel <= '0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_erase_ctrl.sv
module nor_erase_ctrl import era_pkg::*; #(
  parameter int NUM_BLKS  = 8,
  parameter int BLK_WORDS = 4,
  parameter int NUM_BANKS = 2,
  parameter int DATA_W    = 8,
  parameter int TMO_CYC   = 8,
  parameter int ERS_CYC   = 6,
  parameter int NOP_CYC   = 5,
  parameter int SUSP_LAT  = 3,
  localparam int BLK_W    = $clog2(NUM_BLKS),
  localparam int WRD_W    = $clog2(BLK_WORDS),
  localparam int AW       = BLK_W + WRD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [NUM_BLKS-1:0] prot_i,
  input  logic                fault_i,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int BPB = NUM_BLKS / NUM_BANKS;

  era_st_e             st;
  logic [NUM_BLKS-1:0] sel;
  logic                ers_en;
  logic [BLK_W-1:0]    ers_blk;
  logic [DATA_W-1:0]   arr_data;
  logic [DATA_W-1:0]   stat;
  logic [NUM_BANKS-1:0] bank_busy;
  logic [NUM_BLKS-1:0]  blk_busy;
  logic                 busy_st, show_stat, tog;
  logic [BLK_W-1:0]     addr_blk;

  assign addr_blk = addr_i[AW-1:WRD_W];

  era_ctrl #(
    .NUM_BLKS(NUM_BLKS), .DATA_W(DATA_W), .BLK_W(BLK_W), .TMO_CYC(TMO_CYC),
    .ERS_CYC(ERS_CYC), .NOP_CYC(NOP_CYC), .SUSP_LAT(SUSP_LAT)
  ) u_ctrl (
    .clk_i, .rst_ni, .wr_i, .wdata_i, .wr_blk_i(addr_blk), .prot_i, .fault_i,
    .st_o(st), .sel_o(sel), .ers_en_o(ers_en), .ers_blk_o(ers_blk)
  );

  era_array #(
    .NUM_BLKS(NUM_BLKS), .BLK_WORDS(BLK_WORDS), .DATA_W(DATA_W),
    .BLK_W(BLK_W), .AW(AW)
  ) u_arr (
    .clk_i, .rst_ni, .rd_addr_i(addr_i), .rd_data_o(arr_data),
    .ers_en_i(ers_en), .ers_blk_i(ers_blk)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_busy[b] = |sel[b*BPB +: BPB];
  end
  for (genvar k = 0; k < NUM_BLKS; k++) begin : g_blk
    assign blk_busy[k] = bank_busy[k / BPB];
  end

  assign busy_st   = (st == ST_WIN) || (st == ST_ERS) || (st == ST_SPND) || (st == ST_NOP);
  assign show_stat = (st == ST_ERR) || (busy_st && blk_busy[addr_blk]);

  always_comb begin
    stat           = '0;
    stat[STAT_TOG] = tog;
    stat[STAT_ERR] = (st == ST_ERR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      tog     <= 1'b0;
    end else if (rd_i) begin
      if (show_stat) begin
        rdata_o <= stat;
        tog     <= ~tog;
      end else rdata_o <= arr_data;
    end
  end
endmodule

// File: rtl/era_chk.sv
module era_chk import era_pkg::*; #(
  parameter int NUM_BLKS = 8,
  parameter int DATA_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_i,
  input logic                rd_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input era_st_e             st,
  input logic [NUM_BLKS-1:0] sel
);
  logic w_rst, w_susp, w_conf;
  assign w_rst  = wr_i && wdata_i[7:0] == CMD_RST;
  assign w_susp = wr_i && wdata_i[7:0] == CMD_SUSP;
  assign w_conf = wr_i && wdata_i[7:0] == CMD_CONF;

  AST_WIN_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_WIN && w_rst) |=> (st == ST_IDLE && sel == '0)); // R9
  AST_SUSP_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_WIN && w_susp) |=> (st == ST_SUSP)); // R10
  AST_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_SUSP && w_conf) |=> (st == ST_ERS)); // R11
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ERR && !w_rst) |=> (st == ST_ERR)); // R12
  AST_ERR_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ERR && rd_i) |=> rdata_o[STAT_ERR]); // R12
endmodule

bind nor_erase_ctrl era_chk #(.NUM_BLKS(NUM_BLKS), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .st(st), .sel(sel)
);

// File: tb/sim_nor_erase_ctrl.sv
`timescale 1ns/1ps
module sim_nor_erase_ctrl;
  localparam int NB = 8, BW = 4, NBK = 2, DW = 8;
  localparam int TMO = 8, ERS = 6, NOPC = 5, SL = 3;
  localparam int AW = 5, BPB = NB / NBK;

  logic clk_i = 1'b0, rst_ni = 1'b0, wr_i = 1'b0, rd_i = 1'b0, fault_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [NB-1:0] prot_i = '0;
  logic [DW-1:0] rdata_o;

  int total = 0, bad = 0;
  string cur_req = "R1";

  always #5 clk_i = ~clk_i;

  nor_erase_ctrl u0 (.clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i,
                     .prot_i, .fault_i, .rdata_o);

  // reference model: 0 idle,1 cmd,2 win,3 erase,4 susp-req,5 suspended,6 dummy,7 err
  int m_st, m_cnt;
  bit [NB-1:0] m_sel;
  logic [DW-1:0] m_mem [NB*BW];
  bit m_tog;
  logic [DW-1:0] m_rd;

  task automatic m_init();
    m_st = 0; m_cnt = 0; m_sel = '0; m_tog = 0; m_rd = '0;
    for (int i = 0; i < NB*BW; i++) m_mem[i] = DW'(i);
  endtask

  function automatic int m_tgt();
    for (int i = 0; i < NB; i++) if (m_sel[i] && !prot_i[i]) return i;
    return -1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_init();
    else begin
      int blk, t;
      bit busy, show;
      blk = int'(addr_i) / BW;
      t = m_tgt();
      if (rd_i) begin
        busy = 0;
        for (int i = 0; i < NB; i++) if (m_sel[i] && (i / BPB) == (blk / BPB)) busy = 1;
        show = (m_st == 7) || ((m_st == 2 || m_st == 3 || m_st == 4 || m_st == 6) && busy);
        if (show) begin
          m_rd = '0; m_rd[6] = m_tog; m_rd[5] = (m_st == 7); m_tog = !m_tog;
        end else m_rd = m_mem[addr_i];
      end
      case (m_st)
        0: if (wr_i && wdata_i == 8'h80) m_st = 1;
        1: if (wr_i) begin
             if (wdata_i == 8'h30) begin m_sel[blk] = 1; m_cnt = 0; m_st = 2; end
             else m_st = 0;
           end
        2: if (wr_i && wdata_i == 8'h30) begin m_sel[blk] = 1; m_cnt = 0; end
           else if (wr_i && wdata_i == 8'hB0) m_st = 5;
           else if (wr_i && wdata_i == 8'hF0) begin m_st = 0; m_sel = '0; end
           else if (m_cnt == TMO-1) begin m_cnt = 0; m_st = (t >= 0) ? 3 : 6; end
           else m_cnt++;
        3: if (fault_i) m_st = 7;
           else if (wr_i && wdata_i == 8'hB0) begin m_st = 4; m_cnt = 0; end
           else if (t < 0) begin m_st = 0; m_sel = '0; end
           else if (m_cnt == ERS-1) begin
             for (int w = 0; w < BW; w++) m_mem[t*BW + w] = '1;
             m_sel[t] = 0; m_cnt = 0;
           end else m_cnt++;
        4: if (m_cnt == SL-1) m_st = 5; else m_cnt++;
        5: if (wr_i && wdata_i == 8'h30) begin m_st = 3; m_cnt = 0; end
        6: if (m_cnt == NOPC-1) begin m_st = 0; m_sel = '0; end else m_cnt++;
        7: if (wr_i && wdata_i == 8'hF0) begin m_st = 0; m_sel = '0; end
        default: m_st = 0;
      endcase
    end
  end

  // per-clock comparison against the model
  always @(negedge clk_i) if (rst_ni) begin
    total++;
    if (rdata_o !== m_rd) begin
      bad++;
      $display("FAIL %s model compare: got %h exp %h at %0t", cur_req, rdata_o, m_rd, $time);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk_i); wr_i = 1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk_i); wr_i = 0;
  endtask

  task automatic rd_chk(int a, logic [7:0] exp, logic [7:0] mask, string req);
    @(negedge clk_i); rd_i = 1; addr_i = AW'(a);
    @(negedge clk_i); rd_i = 0;
    total++;
    if ((rdata_o & mask) !== (exp & mask)) begin
      bad++;
      $display("FAIL %s read %0d: got %h exp %h (mask %h)", req, a, rdata_o, exp, mask);
    end
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired: got hang exp finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_init();
    idle(3); rst_ni = 1; idle(1);
    // R1 reset state and array pattern
    cur_req = "R1";
    total++;
    if (rdata_o !== '0) begin bad++; $display("FAIL R1 reset rdata: got %h exp 00", rdata_o); end
    rd_chk(5, 8'd5, 8'hFF, "R1");
    rd_chk(30, 8'd30, 8'hFF, "R1");

    // R2 stray writes and broken sequence
    cur_req = "R2";
    wr(4, 8'hA5); idle(20); rd_chk(4, 8'd4, 8'hFF, "R2");
    wr(4, 8'h80); wr(4, 8'h55); idle(20); rd_chk(4, 8'd4, 8'hFF, "R2");

    // R3 R6 R7 R8 two blocks in bank 0
    cur_req = "R3";
    wr(0, 8'h80); wr(4, 8'h30); idle(2); wr(8, 8'h30);
    rd_chk(16, 8'd16, 8'hFF, "R8");
    rd_chk(12, 8'h00, 8'hFF, "R7");
    rd_chk(12, 8'h40, 8'hFF, "R7");
    idle(40);
    rd_chk(4, 8'hFF, 8'hFF, "R3");
    rd_chk(11, 8'hFF, 8'hFF, "R3");
    rd_chk(12, 8'd12, 8'hFF, "R6");

    // R4 protected block skipped
    cur_req = "R4";
    prot_i = 8'b0000_1000;
    wr(0, 8'h80); wr(12, 8'h30); wr(16, 8'h30);
    rd_chk(17, 8'h00, 8'hBF, "R4");
    idle(40);
    rd_chk(12, 8'd12, 8'hFF, "R4");
    rd_chk(16, 8'hFF, 8'hFF, "R4");

    // R5 all selected blocks protected
    cur_req = "R5";
    prot_i = 8'b0100_0000;
    wr(0, 8'h80); wr(24, 8'h30); idle(10);
    rd_chk(25, 8'h00, 8'hBF, "R5");
    idle(20);
    rd_chk(25, 8'd25, 8'hFF, "R5");
    prot_i = '0;

    // R9 cancel in window, ignored during erase
    cur_req = "R9";
    wr(0, 8'h80); wr(0, 8'h30); idle(2); wr(0, 8'hF0); idle(30);
    rd_chk(3, 8'd3, 8'hFF, "R9");
    wr(0, 8'h80); wr(20, 8'h30); idle(10); wr(0, 8'hF0); idle(20);
    rd_chk(20, 8'hFF, 8'hFF, "R9");

    // R10 R11 suspend in window, then resume
    cur_req = "R10";
    wr(0, 8'h80); wr(28, 8'h30); idle(2); wr(28, 8'hB0);
    rd_chk(28, 8'd28, 8'hFF, "R10");
    cur_req = "R11";
    wr(28, 8'h30); idle(25);
    rd_chk(28, 8'hFF, 8'hFF, "R11");

    // R10 R11 suspend with latency during erase
    cur_req = "R10";
    wr(0, 8'h80); wr(0, 8'h30); idle(12); wr(0, 8'hB0);
    rd_chk(1, 8'h00, 8'hBF, "R10");
    idle(5);
    rd_chk(1, 8'd1, 8'hFF, "R10");
    cur_req = "R11";
    wr(0, 8'h30); idle(20);
    rd_chk(1, 8'hFF, 8'hFF, "R11");

    // R12 R6 fault after first block of two
    cur_req = "R12";
    wr(0, 8'h80); wr(12, 8'h30); wr(24, 8'h30);
    idle(15); fault_i = 1; idle(1); fault_i = 0;
    idle(3);
    rd_chk(0, 8'h20, 8'hBF, "R12");
    idle(10);
    rd_chk(2, 8'h20, 8'hBF, "R12");
    wr(0, 8'hF0);
    rd_chk(12, 8'hFF, 8'hFF, "R6");
    rd_chk(24, 8'd24, 8'hFF, "R6");

    idle(5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule